// File: doc/BRIEF.md
# MMU Fault Status Recorder

This block keeps the fault status words for the instruction side and the data side of a memory management unit. On the data side it also keeps the address of the faulting access. Other logic decides that a fault has happened. It then pulses a single fault strobe, marks which side the fault belongs to, and presents the fault details: whether the access was a write, the kind of context used, whether the target page has side effects, a fault type code, and the 8-bit address space identifier. The block packs these fields into a fixed layout and stores the result in the status word of the chosen side, one clock edge after the strobe.

A second fault can arrive before software has cleared the first one. When that happens the block sets an overwrite flag next to the valid flag. Software can then tell that at least one record was lost.

Software uses a small select-and-write port. It can read any of the three registers combinationally. It can load a register with a new value, and writing zero clears it. If a fault and a software write hit the same register in the same cycle, the fault is kept.

Top module: `mmu_fault_status`

## Requirements
- R1: After a synchronous active-low reset, the instruction status word, the data status word and the data fault address all read as zero.
- R2: A fault recorded into a status word whose bit 0 is clear leaves bit 0 set and bit 1 clear.
- R3: A fault recorded into a status word whose bit 0 is already set leaves both bit 0 and bit 1 (overwrite) set.
- R4: Bit 2 of the recorded word equals the write flag of the faulting access.
- R5: Bits 5:4 hold the context kind, encoded as primary = 0, secondary = 1, nucleus = 2.
- R6: Bit 6 equals the side-effect flag of the faulting access.
- R7: Bits 12:7 hold the fault type code, encoded as other = 0, privilege violation = 1, load from no-fault page = 2, illegal address space = 3, address out of range = 5.
- R8: Bits 23:16 hold the 8-bit address space identifier, and bits 3, 15:13 and 63:24 of a recorded word are zero.
- R9: A data-side fault copies the zero-extended fault address into the fault address register. An instruction-side fault leaves that register unchanged.
- R10: A fault changes only the status word of its own side.
- R11: A software write with select 0 (instruction status), 1 (data status) or 2 (fault address) loads the written value, and writing zero clears the register. After such a clear, the next fault does not set the overwrite bit.
- R12: When a fault and a software write target the same status word in the same cycle, the fault record is stored. Its overwrite bit follows the value the word held before that cycle.
- R13: Select 3 reads as zero, and a software write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flt_req | input | 1 | Fault strobe, one cycle per fault |
| flt_dside | input | 1 | 1 = data-side fault, 0 = instruction-side fault |
| flt_write | input | 1 | Faulting access was a write |
| flt_ctx | input | 2 | Context kind |
| flt_sidefx | input | 1 | Target page has side effects |
| flt_type | input | FT_W (6) | Fault type code |
| flt_asi | input | ASI_W (8) | Address space identifier |
| flt_addr | input | VA_W (48) | Faulting virtual address |
| sw_sel | input | 2 | Register select for software read and write |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | DATA_W (64) | Software write data |
| sw_rdata | output | DATA_W (64) | Selected register contents |

## Verification
The bench uses the default parameters: 64-bit registers, a 48-bit fault address, a 6-bit fault type field and an 8-bit identifier. With these values the upper identifier bit and the upper address bits are exercised, so the field boundaries at bits 23 and 47 and the zero padding above them are observable. All five fault type codes and all three context kinds are driven. Both the same-cycle collision of a fault with a clear and back-to-back faults on one side are covered.

// File: rtl/mmu_fault_pkg.sv
// Shared layout and encodings for the MMU fault status recorder.
// Assumes the fault type field fits below the identifier field.
package mmu_fault_pkg;
    localparam int VALID_BIT  = 0;
    localparam int OVR_BIT    = 1;
    localparam int WRITE_BIT  = 2;
    localparam int CTX_LSB    = 4;
    localparam int CTX_W      = 2;
    localparam int SIDEFX_BIT = 6;
    localparam int FTYPE_LSB  = 7;
    localparam int ASI_LSB    = 16;

    typedef enum logic [CTX_W-1:0] {
        CTX_PRIMARY   = 2'd0,
        CTX_SECONDARY = 2'd1,
        CTX_NUCLEUS   = 2'd2
    } ctx_kind_e;

    localparam logic [5:0] FT_OTHER      = 6'd0;
    localparam logic [5:0] FT_PRIV_VIOL  = 6'd1;
    localparam logic [5:0] FT_NOFAULT_LD = 6'd2;
    localparam logic [5:0] FT_BAD_ASI    = 6'd3;
    localparam logic [5:0] FT_VA_RANGE   = 6'd5;

    localparam int SEL_ISTAT = 0;
    localparam int SEL_DSTAT = 1;
    localparam int SEL_DADDR = 2;
endpackage

// File: rtl/fault_rec_pack.sv
// Packs the fault detail fields into a status word layout. Bits 1:0
// (valid and overwrite) are left at zero for the register to fill.
// Assumes FTYPE_LSB + FT_W <= ASI_LSB and ASI_LSB + ASI_W <= DATA_W.
module fault_rec_pack
    import mmu_fault_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int FT_W   = 6,
    parameter int ASI_W  = 8
) (
    input  logic              is_write,
    input  logic [CTX_W-1:0]  ctx,
    input  logic              sidefx,
    input  logic [FT_W-1:0]   ftype,
    input  logic [ASI_W-1:0]  asi,
    output logic [DATA_W-1:0] rec
);
    // Place each field at its fixed position; all other bits stay zero.
    always_comb begin
        rec = '0;
        rec[WRITE_BIT]                 = is_write;
        rec[CTX_LSB +: CTX_W]          = ctx;
        rec[SIDEFX_BIT]                = sidefx;
        rec[FTYPE_LSB +: FT_W]         = ftype;
        rec[ASI_LSB +: ASI_W]          = asi;
    end
endmodule

// File: rtl/fault_stat_reg.sv
// One fault status word. A fault stores the packed record with the
// valid bit set and with the overwrite bit set if the word was already
// valid. A software write loads its data unless a fault lands in the
// same cycle, in which case the fault wins.
module fault_stat_reg #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_hit,
    input  logic [DATA_W-1:0] rec,
    input  logic              sw_hit,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] stat
);
    logic [DATA_W-1:0] flt_word;

    // Combine the record with the valid flag and the overwrite flag.
    always_comb begin
        flt_word    = rec;
        flt_word[0] = 1'b1;
        flt_word[1] = stat[0];
    end

    // Update the word: reset, then fault, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)          stat <= '0;
        else if (fault_hit)  stat <= flt_word;
        else if (sw_hit)     stat <= sw_wdata;
    end

    AST_VALID_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |=> stat[0]);                                   // R2
    AST_FRESH_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit && !stat[0] |=> !stat[1]);                      // R2
    AST_OVERWRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit && stat[0] |=> stat[1]);                        // R3
    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit && sw_hit |=> stat[0]);                         // R12
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sw_hit && !fault_hit |=> stat == $past(sw_wdata));        // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_hit && !sw_hit |=> $stable(stat));                 // R10
endmodule

// File: rtl/mmu_fault_status.sv
// Fault status recorder for both sides of an MMU, plus the data-side
// fault address register. Assumes flt_req is a one-cycle strobe per
// fault and VA_W <= DATA_W. Software reads are combinational.
module mmu_fault_status
    import mmu_fault_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int VA_W   = 48,
    parameter int FT_W   = 6,
    parameter int ASI_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_req,
    input  logic              flt_dside,
    input  logic              flt_write,
    input  logic [1:0]        flt_ctx,
    input  logic              flt_sidefx,
    input  logic [FT_W-1:0]   flt_type,
    input  logic [ASI_W-1:0]  flt_asi,
    input  logic [VA_W-1:0]   flt_addr,
    input  logic [1:0]        sw_sel,
    input  logic              sw_wr,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata
);
    localparam int NSIDE = 2;

    logic [DATA_W-1:0] rec;
    logic [DATA_W-1:0] stat [NSIDE];
    logic [DATA_W-1:0] daddr;
    logic              far_flt;
    logic              far_sw;

    fault_rec_pack #(.DATA_W(DATA_W), .FT_W(FT_W), .ASI_W(ASI_W)) u_pack (
        .is_write (flt_write),
        .ctx      (flt_ctx),
        .sidefx   (flt_sidefx),
        .ftype    (flt_type),
        .asi      (flt_asi),
        .rec      (rec)
    );

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        logic f_hit;
        logic w_hit;
        // Route the fault strobe and software write to this side.
        always_comb begin
            f_hit = flt_req && (flt_dside == s[0]);
            w_hit = sw_wr && (sw_sel == 2'(s));
        end
        fault_stat_reg #(.DATA_W(DATA_W)) u_stat (
            .clk      (clk),
            .rst_n    (rst_n),
            .fault_hit(f_hit),
            .rec      (rec),
            .sw_hit   (w_hit),
            .sw_wdata (sw_wdata),
            .stat     (stat[s])
        );
    end

    // Decode which event updates the fault address register.
    always_comb begin
        far_flt = flt_req && flt_dside;
        far_sw  = sw_wr && (sw_sel == 2'(SEL_DADDR));
    end

    // Fault address register: data-side fault first, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        daddr <= '0;
        else if (far_flt)  daddr <= DATA_W'(flt_addr);
        else if (far_sw)   daddr <= sw_wdata;
    end

    // Software read multiplexer; the unused select reads zero.
    always_comb begin
        case (sw_sel)
            2'(SEL_ISTAT): sw_rdata = stat[0];
            2'(SEL_DSTAT): sw_rdata = stat[1];
            2'(SEL_DADDR): sw_rdata = daddr;
            default:       sw_rdata = '0;
        endcase
    end

    AST_FAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        flt_req && flt_dside |=> daddr == DATA_W'($past(flt_addr)));   // R9
    AST_FAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_req && flt_dside) && !(sw_wr && sw_sel == 2'd2) |=> $stable(daddr)); // R9
    AST_ISIDE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        flt_req && flt_dside && !(sw_wr && sw_sel == 2'd0) |=> $stable(stat[0])); // R10
    AST_SEL3_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr && sw_sel == 2'd3 && !flt_req |=> $stable(stat[1]) && $stable(daddr)); // R13
endmodule

// File: tb/mmu_fault_status_bench.sv
module mmu_fault_status_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flt_req, flt_dside, flt_write, flt_sidefx;
    logic [1:0]  flt_ctx;
    logic [5:0]  flt_type;
    logic [7:0]  flt_asi;
    logic [47:0] flt_addr;
    logic [1:0]  sw_sel;
    logic        sw_wr;
    logic [63:0] sw_wdata;
    logic [63:0] sw_rdata;

    int vec_cnt = 0;
    int err_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_fault_status u_mmu_fault_status (
        .clk(clk), .rst_n(rst_n), .flt_req(flt_req), .flt_dside(flt_dside),
        .flt_write(flt_write), .flt_ctx(flt_ctx), .flt_sidefx(flt_sidefx),
        .flt_type(flt_type), .flt_asi(flt_asi), .flt_addr(flt_addr),
        .sw_sel(sw_sel), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
    );

    function automatic logic [63:0] exp_word(input logic ovr, input logic w,
        input logic [1:0] c, input logic se, input logic [5:0] ft, input logic [7:0] a);
        return 64'h1 | (64'(ovr) << 1) | (64'(w) << 2) | (64'(c) << 4)
             | (64'(se) << 6) | (64'(ft) << 7) | (64'(a) << 16);
    endfunction

    task automatic check_reg(input logic [1:0] sel, input logic [63:0] exp, input string req);
        sw_sel = sel;
        #1;
        vec_cnt++;
        if (sw_rdata !== exp) begin
            err_cnt++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, sw_rdata, exp);
        end
    endtask

    task automatic fault(input logic d, input logic w, input logic [1:0] c,
        input logic se, input logic [5:0] ft, input logic [7:0] a, input logic [47:0] va);
        @(negedge clk);
        flt_req = 1; flt_dside = d; flt_write = w; flt_ctx = c;
        flt_sidefx = se; flt_type = ft; flt_asi = a; flt_addr = va;
        @(negedge clk);
        flt_req = 0;
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [63:0] v);
        @(negedge clk);
        sw_sel = sel; sw_wr = 1; sw_wdata = v;
        @(negedge clk);
        sw_wr = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_reg(2'd0, 64'h0, "R1");
        check_reg(2'd1, 64'h0, "R1");
        check_reg(2'd2, 64'h0, "R1");
    endtask

    task automatic t_first_and_overwrite;
        fault(1'b0, 1'b1, 2'd0, 1'b0, 6'd1, 8'h80, 48'h0);
        check_reg(2'd0, exp_word(0, 1, 2'd0, 0, 6'd1, 8'h80), "R2");
        fault(1'b0, 1'b0, 2'd2, 1'b1, 6'd5, 8'h14, 48'h0);
        check_reg(2'd0, exp_word(1, 0, 2'd2, 1, 6'd5, 8'h14), "R3");
    endtask

    task automatic t_fields;
        logic [5:0] codes [5] = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd5};
        sw_write(2'd1, 64'h0);
        for (int k = 0; k < 5; k++) begin
            logic [1:0] c;
            c = 2'(k % 3);
            sw_write(2'd1, 64'h0);
            fault(1'b1, k[0], c, k[1], codes[k], 8'(8'hF0 ^ (k * 37)), 48'h1000 + 48'(k));
            check_reg(2'd1, exp_word(0, k[0], c, k[1], codes[k], 8'(8'hF0 ^ (k * 37))),
                      "R4 R5 R6 R7 R8");
        end
        sw_write(2'd1, 64'h0);
        fault(1'b1, 1'b1, 2'd1, 1'b1, 6'd3, 8'hFF, 48'hFFFF_FFFF_FFF8);
        check_reg(2'd1, 64'h0000_0000_00FF_01D5, "R8");
    endtask

    task automatic t_sides;
        logic [63:0] istat_before;
        sw_sel = 2'd0; #1 istat_before = sw_rdata;
        fault(1'b1, 1'b0, 2'd0, 1'b0, 6'd2, 8'h2A, 48'hABCD_1234_5678);
        check_reg(2'd2, 64'h0000_ABCD_1234_5678, "R9");
        check_reg(2'd0, istat_before, "R10");
        check_reg(2'd1, exp_word(1, 0, 2'd0, 0, 6'd2, 8'h2A), "R3");
        fault(1'b0, 1'b0, 2'd1, 1'b0, 6'd0, 8'h04, 48'h1111_2222_3333);
        check_reg(2'd2, 64'h0000_ABCD_1234_5678, "R9");
        check_reg(2'd1, exp_word(1, 0, 2'd0, 0, 6'd2, 8'h2A), "R10");
    endtask

    task automatic t_sw_clear;
        sw_write(2'd0, 64'h0);
        check_reg(2'd0, 64'h0, "R11");
        sw_write(2'd2, 64'hDEAD_BEEF_0000_0001);
        check_reg(2'd2, 64'hDEAD_BEEF_0000_0001, "R11");
        fault(1'b0, 1'b0, 2'd1, 1'b0, 6'd3, 8'h19, 48'h0);
        check_reg(2'd0, exp_word(0, 0, 2'd1, 0, 6'd3, 8'h19), "R11");
    endtask

    task automatic t_collision;
        @(negedge clk);
        flt_req = 1; flt_dside = 0; flt_write = 1; flt_ctx = 2'd2;
        flt_sidefx = 0; flt_type = 6'd1; flt_asi = 8'h58; flt_addr = '0;
        sw_sel = 2'd0; sw_wr = 1; sw_wdata = 64'h0;
        @(negedge clk);
        flt_req = 0; sw_wr = 0;
        check_reg(2'd0, exp_word(1, 1, 2'd2, 0, 6'd1, 8'h58), "R12");
    endtask

    task automatic t_unused_sel;
        logic [63:0] a, b, c;
        sw_sel = 2'd0; #1 a = sw_rdata;
        sw_sel = 2'd1; #1 b = sw_rdata;
        sw_sel = 2'd2; #1 c = sw_rdata;
        sw_write(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        check_reg(2'd3, 64'h0, "R13");
        check_reg(2'd0, a, "R13");
        check_reg(2'd1, b, "R13");
        check_reg(2'd2, c, "R13");
    endtask

    initial begin
        rst_n = 0; flt_req = 0; flt_dside = 0; flt_write = 0; flt_ctx = 0;
        flt_sidefx = 0; flt_type = 0; flt_asi = 0; flt_addr = 0;
        sw_sel = 0; sw_wr = 0; sw_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_first_and_overwrite();
        t_fields();
        t_sides();
        t_sw_clear();
        t_collision();
        t_unused_sel();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        err_cnt++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end
endmodule